// File: doc/BRIEF.md
# Coin-Accumulating Vending Release Controller

This block controls a single-item vending machine whose item costs 30 cents. The coin sensor reports each event as a one-cycle strobe together with one coin bit. The machine takes only two coin kinds, 10 cents and 25 cents. It keeps a running credit in a small Moore state machine and drives a release line once the credit reaches the price. Overpayment is absorbed, and no change is returned.

Removal of the item by the customer is reported through the same sensor, as a strobed event with the 10-cent code. This event returns the machine to idle. The state advances only on strobe cycles, so the clock can run freely. The release output comes from a flip-flop that is loaded with the decoded next state. It therefore switches on the same edge as the state and carries no decode glitches.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first clock after it rises, release_o is 0 and the machine is idle (zero credit).
- R2: An event is a cycle with evt_valid_i = 1. evt_coin_i = 0 codes a 10-cent coin and evt_coin_i = 1 codes a 25-cent coin.
- R3: From idle, an event of either coin leaves release_o at 0. A 10-cent coin sets the credit to 10 and a 25-cent coin sets it to 25.
- R4: From a credit of 10, a 10-cent coin moves to a credit of 20 with release_o at 0. A 25-cent coin raises release_o on the clock edge that takes the event.
- R5: From a credit of 20 or 25, an event of either coin raises release_o on the clock edge that takes the event. No change is given.
- R6: While release_o is 1, the next event (a removal, coded 0, although either code is accepted) returns the machine to idle. release_o drops on that edge.
- R7: In a cycle with evt_valid_i = 0, the state and release_o hold, whatever the value of evt_coin_i.
- R8: release_o is a registered output. It is 1 exactly while the machine is in the release state, and it changes only on the clock edge that takes an event or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | One-cycle sensor event strobe |
| evt_coin_i | input | 1 | Coin code of the event: 0 = 10 cents or removal, 1 = 25 cents |
| release_o | output | 1 | Item release, high while the credit has reached the price |

## Verification
The block has no size parameters, so the bench builds it in its single fixed configuration. From reset, the bench sweeps every coin-code sequence of one to five events, which reaches every state and every transition, including the removal from the release state and a second purchase after it. The expected release level comes from an arithmetic credit model: the coin values are summed, and the credit is compared with the price. Idle gaps with a toggling coin bit, and a reset asserted during vending, confirm the hold and reset behaviour.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_TEN     = 3'd1,
    ST_TWENTY  = 3'd2,
    ST_VEND    = 3'd3,
    ST_QUARTER = 3'd4
  } vend_state_e;

  typedef enum logic {
    COIN_DIME    = 1'b0,
    COIN_QUARTER = 1'b1
  } coin_e;
endpackage

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
(
  input  vend_state_e state_i,
  input  logic        valid_i,
  input  logic        coin_i,
  output vend_state_e state_o
);
  coin_e coin;
  assign coin = coin_e'(coin_i);

  always_comb begin
    state_o = state_i;
    if (valid_i) begin
      unique case (state_i)
        ST_IDLE:    state_o = (coin == COIN_QUARTER) ? ST_QUARTER : ST_TEN;
        ST_TEN:     state_o = (coin == COIN_QUARTER) ? ST_VEND : ST_TWENTY;
        ST_TWENTY:  state_o = ST_VEND;
        ST_QUARTER: state_o = ST_VEND;
        ST_VEND:    state_o = ST_IDLE;  // removal event
        default:    state_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vend_release_reg.sv
module vend_release_reg
  import vend_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  vend_state_e state_d_i,
  output logic        release_o
);
  // loaded from next state so it aligns with the state register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) release_o <= 1'b0;
    else         release_o <= (state_d_i == ST_VEND);
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_valid_i,
  input  logic evt_coin_i,
  output logic release_o
);
  vend_state_e state_q, state_d;

  vend_next_state u_next (
    .state_i (state_q),
    .valid_i (evt_valid_i),
    .coin_i  (evt_coin_i),
    .state_o (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  vend_release_reg u_rel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .release_o (release_o)
  );

  // R8: output register tracks the state register
  a_r8_release_matches_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o == (state_q == ST_VEND));

  // R7: no strobe, no change
  a_r7_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> $stable(release_o));
  a_r7_hold_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> $stable(state_q));

  // R6: removal clears release
  a_r6_removal_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o && evt_valid_i) |=> (!release_o && state_q == ST_IDLE));

  // R3: first coin never releases
  a_r3_first_coin_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && evt_valid_i) |=> !release_o);

  // R5: 20 or 25 cents plus any coin releases
  a_r5_any_coin_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TWENTY || state_q == ST_QUARTER) && evt_valid_i) |=> release_o);

  // R4: 10 cents plus quarter releases
  a_r4_ten_quarter_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEN && evt_valid_i && evt_coin_i) |=> release_o);
endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PRICE      = 30;
  localparam int unsigned VEND_MARK  = 1000;
  localparam int unsigned MAX_LEN    = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid_i = 1'b0;
  logic evt_coin_i = 1'b0;
  logic release_o;

  int checks = 0;
  int errors = 0;
  int credit = 0;  // VEND_MARK means release state

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vend_ctrl u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .evt_coin_i  (evt_coin_i),
    .release_o   (release_o)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (release_o !== exp) begin
      errors++;
      $display("FAIL %s: release_o=%b expected %b (credit %0d)", req, release_o, exp, credit);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    evt_valid_i = 1'b0;
    #1;
    check(1'b0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    credit = 0;
    @(negedge clk_i);
    check(1'b0, "R1");
  endtask

  task automatic do_event(input logic coin);
    string req;
    if (credit == VEND_MARK)                req = "R6";
    else if (credit == 0)                   req = "R3";
    else if (credit == 10)                  req = "R4";
    else                                    req = "R5";
    evt_valid_i = 1'b1;
    evt_coin_i  = coin;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    if (credit == VEND_MARK) credit = 0;
    else begin
      credit += coin ? 25 : 10;
      if (credit >= PRICE) credit = VEND_MARK;
    end
    check(credit == VEND_MARK, req);
  endtask

  task automatic idle_gap(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      evt_coin_i = ~evt_coin_i;
      @(negedge clk_i);
      check(credit == VEND_MARK, "R7");
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check(1'b0, "R1");
    do_reset();

    // R2 encoding: the five paying sequences, each followed by removal (R6)
    do_event(0); do_event(0); do_event(0); idle_gap(2); do_event(0); idle_gap(1);
    do_event(0); do_event(0); do_event(1); do_event(0);
    do_event(0); do_event(1); idle_gap(3); do_event(0);
    do_event(1); do_event(0); do_event(0);
    do_event(1); idle_gap(2); do_event(1); do_event(1);  // removal with quarter code
    idle_gap(2);

    // sweep every sequence of 1..MAX_LEN events
    for (int len = 1; len <= MAX_LEN; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        do_reset();
        for (int k = 0; k < len; k++) begin
          do_event(pat[k]);
          if (k[0]) idle_gap(1);
        end
      end
    end

    // R1: async reset while release is high
    do_reset();
    do_event(1); do_event(1);
    check(1'b1, "R5");
    do_reset();
    do_event(0); do_event(0);
    check(1'b0, "R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule